// File: doc/BRIEF.md
# Receiver Polling Mode Sequencer

This block is the control state machine of a duty-cycled radio receiver. It steps through four modes: sleep, start-up, bit-check and receiving. In sleep a programmable cycle count runs down. Start-up waits for the analog front end to report that it has settled. Bit-check waits for a pass/fail verdict from an external measurement unit. Receiving holds until software issues an OFF command.

A polling-enable pin level selects how the sequencer leaves receiving mode. When the pin is high, an OFF command sends it back into the full polling cycle, sleep period included. When the pin is low, the receiver stays in receiving mode for as long as no OFF arrives. An OFF under a low pin skips the sleep period and goes straight to start-up, followed by a fresh bit check. This lets a host suppress the noise that follows the end of a frame without losing the link. A noise-disable configuration bit is passed through, registered, as a status output.

Top module: `rx_poll_seq`

## Requirements
- R1: While reset is asserted and after its release, `mode_o` reads 0 (sleep), `sleep_tmr_en_o` is 1 and `noise_dis_o` is 0. The sleep counter starts cleared, so the first sleep period has its full programmed length.
- R2: With the polling pin high, sleep (mode 0) lasts exactly `sleep_cycles_i` cycles, or one cycle when that value is 0, and is then followed by start-up (mode 1). `sleep_tmr_en_o` is 1 exactly while the mode is sleep.
- R3: Start-up (mode 1) holds until `startup_done_i` is sampled high. On the next cycle the mode becomes bit-check (mode 2).
- R4: In bit-check, a cycle with `chk_done_i`=1 and `chk_ok_i`=1 moves the mode to receiving (mode 3) on the next cycle.
- R5: In bit-check, a cycle with `chk_done_i`=1 and `chk_ok_i`=0 moves the mode to sleep when the polling pin is high. When the pin is low, the mode stays in bit-check for a retry.
- R6: In receiving mode, without an OFF strobe, the mode stays receiving whatever the polling pin level.
- R7: An OFF strobe in receiving mode with the polling pin low moves the mode to start-up, so no sleep cycle occurs. A new bit check then follows.
- R8: An OFF strobe in receiving mode with the polling pin high moves the mode to sleep, and the full programmed sleep period then runs.
- R9: An OFF strobe in sleep, start-up or bit-check has no effect on the mode.
- R10: A low polling pin during sleep ends the sleep period: the mode becomes start-up on the next cycle.
- R11: `noise_dis_o` equals `noise_dis_i` delayed by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_en_i | input | 1 | Polling pin level; high enables the sleep period |
| off_cmd_i | input | 1 | Single-cycle OFF command strobe |
| chk_done_i | input | 1 | Bit-check verdict valid strobe |
| chk_ok_i | input | 1 | Bit-check verdict: 1 pass, 0 fail |
| startup_done_i | input | 1 | Front end settled |
| sleep_cycles_i | input | SLEEP_W | Programmed sleep length in cycles |
| noise_dis_i | input | 1 | Noise-disable configuration bit |
| mode_o | output | 2 | Mode: 0 sleep, 1 start-up, 2 bit-check, 3 receiving |
| sleep_tmr_en_o | output | 1 | Sleep timer running |
| noise_dis_o | output | 1 | Registered noise-disable status |

## Verification
The assertions check every mode transition rule on every cycle: the start-up hold, the pass and fail exits from bit-check under either pin level, the receiving hold, both OFF paths, the early exit from sleep on a low pin, and the one-cycle delay on the noise status bit. A counter in the checker bounds each sleep run to the programmed length. The bench scenarios are needed to show the exact sleep length, including the zero-length case. They also show that OFF strobes outside receiving mode leave no trace, and they follow the full low-pin recovery path from receiving through start-up and bit-check back to receiving.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STARTUP = 2'd1,
    MODE_BITCHK  = 2'd2,
    MODE_RECV    = 2'd3
  } rx_mode_e;
endpackage

// File: rtl/rx_poll_sleep_timer.sv
module rx_poll_sleep_timer #(
  parameter int unsigned SLEEP_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [SLEEP_W-1:0] limit_i,
  output logic               expire_o
);
  localparam int unsigned CW = SLEEP_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  // zero length behaves as one cycle
  assign lim      = (limit_i == '0) ? CW'(1) : {1'b0, limit_i};
  assign expire_o = run_i && ((cnt_q + CW'(1)) >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/rx_poll_fsm.sv
module rx_poll_fsm
  import rx_poll_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     poll_en_i,
  input  logic     off_cmd_i,
  input  logic     chk_done_i,
  input  logic     chk_ok_i,
  input  logic     startup_done_i,
  input  logic     sleep_expire_i,
  output rx_mode_e mode_o
);
  rx_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_SLEEP: begin
        if (!poll_en_i || sleep_expire_i) mode_d = MODE_STARTUP;
      end
      MODE_STARTUP: begin
        if (startup_done_i) mode_d = MODE_BITCHK;
      end
      MODE_BITCHK: begin
        if (chk_done_i) begin
          if (chk_ok_i)       mode_d = MODE_RECV;
          else if (poll_en_i) mode_d = MODE_SLEEP;
        end
      end
      MODE_RECV: begin
        // low pin: skip sleep, re-run bit check
        if (off_cmd_i) mode_d = poll_en_i ? MODE_SLEEP : MODE_STARTUP;
      end
      default: mode_d = MODE_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_SLEEP;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq
  import rx_poll_pkg::*;
#(
  parameter int unsigned SLEEP_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               poll_en_i,
  input  logic               off_cmd_i,
  input  logic               chk_done_i,
  input  logic               chk_ok_i,
  input  logic               startup_done_i,
  input  logic [SLEEP_W-1:0] sleep_cycles_i,
  input  logic               noise_dis_i,
  output logic [1:0]         mode_o,
  output logic               sleep_tmr_en_o,
  output logic               noise_dis_o
);
  rx_mode_e mode;
  logic     in_sleep;
  logic     expire;
  logic     noise_q;

  assign in_sleep = (mode == MODE_SLEEP);

  rx_poll_sleep_timer #(.SLEEP_W(SLEEP_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (in_sleep),
    .limit_i  (sleep_cycles_i),
    .expire_o (expire)
  );

  rx_poll_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .poll_en_i      (poll_en_i),
    .off_cmd_i      (off_cmd_i),
    .chk_done_i     (chk_done_i),
    .chk_ok_i       (chk_ok_i),
    .startup_done_i (startup_done_i),
    .sleep_expire_i (expire),
    .mode_o         (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) noise_q <= 1'b0;
    else         noise_q <= noise_dis_i;
  end

  assign mode_o         = mode;
  assign sleep_tmr_en_o = in_sleep;
  assign noise_dis_o    = noise_q;
endmodule

// File: rtl/rx_poll_seq_chk.sv
module rx_poll_seq_chk #(
  parameter int unsigned SLEEP_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               poll_en_i,
  input logic               off_cmd_i,
  input logic               chk_done_i,
  input logic               chk_ok_i,
  input logic               startup_done_i,
  input logic [SLEEP_W-1:0] sleep_cycles_i,
  input logic               noise_dis_i,
  input logic [1:0]         mode_o,
  input logic               sleep_tmr_en_o,
  input logic               noise_dis_o
);
  localparam int unsigned CW = SLEEP_W + 1;
  logic [CW-1:0] run_q;
  logic [CW-1:0] lim;

  assign lim = (sleep_cycles_i == '0) ? CW'(1) : {1'b0, sleep_cycles_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_q <= '0;
    else if (mode_o == 2'd0) run_q <= run_q + CW'(1);
    else                     run_q <= '0;
  end

  // R2
  sleep_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0) |-> (run_q < lim));
  // R2
  tmr_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_tmr_en_o |-> (mode_o == 2'd0));
  // R3
  startup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && !startup_done_i) |=> (mode_o == 2'd1));
  // R3
  startup_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && startup_done_i) |=> (mode_o == 2'd2));
  // R4
  chk_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && chk_done_i && chk_ok_i) |=> (mode_o == 2'd3));
  // R5
  chk_fail_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && chk_done_i && !chk_ok_i && poll_en_i) |=> (mode_o == 2'd0));
  // R5
  chk_fail_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && chk_done_i && !chk_ok_i && !poll_en_i) |=> (mode_o == 2'd2));
  // R6
  recv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && !off_cmd_i) |=> (mode_o == 2'd3));
  // R7
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && off_cmd_i && !poll_en_i) |=> (mode_o == 2'd1));
  // R8
  off_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && off_cmd_i && poll_en_i) |=> (mode_o == 2'd0));
  // R10
  sleep_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && !poll_en_i) |=> (mode_o == 2'd1));
  // R11
  noise_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (noise_dis_o == $past(noise_dis_i)));
endmodule

bind rx_poll_seq rx_poll_seq_chk #(.SLEEP_W(SLEEP_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .poll_en_i      (poll_en_i),
  .off_cmd_i      (off_cmd_i),
  .chk_done_i     (chk_done_i),
  .chk_ok_i       (chk_ok_i),
  .startup_done_i (startup_done_i),
  .sleep_cycles_i (sleep_cycles_i),
  .noise_dis_i    (noise_dis_i),
  .mode_o         (mode_o),
  .sleep_tmr_en_o (sleep_tmr_en_o),
  .noise_dis_o    (noise_dis_o)
);

// File: tb/rx_poll_seq_tb.sv
module rx_poll_seq_tb;
  localparam int unsigned SLEEP_W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               poll_en_i = 1'b1;
  logic               off_cmd_i = 1'b0;
  logic               chk_done_i = 1'b0;
  logic               chk_ok_i = 1'b0;
  logic               startup_done_i = 1'b0;
  logic [SLEEP_W-1:0] sleep_cycles_i = 8'd5;
  logic               noise_dis_i = 1'b0;
  logic [1:0]         mode_o;
  logic               sleep_tmr_en_o;
  logic               noise_dis_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  rx_poll_seq #(.SLEEP_W(SLEEP_W)) u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .poll_en_i      (poll_en_i),
    .off_cmd_i      (off_cmd_i),
    .chk_done_i     (chk_done_i),
    .chk_ok_i       (chk_ok_i),
    .startup_done_i (startup_done_i),
    .sleep_cycles_i (sleep_cycles_i),
    .noise_dis_i    (noise_dis_i),
    .mode_o         (mode_o),
    .sleep_tmr_en_o (sleep_tmr_en_o),
    .noise_dis_o    (noise_dis_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: inputs applied at negedge, outputs sampled at next negedge
  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    off_cmd_i      = 1'b0;
    chk_done_i     = 1'b0;
    chk_ok_i       = 1'b0;
    startup_done_i = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check("R1 mode in reset", int'(mode_o), 0);
    check("R1 tmr_en in reset", int'(sleep_tmr_en_o), 1);
    check("R1 noise in reset", int'(noise_dis_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_sleep_run(input int exp_len, input string req);
    int len = 0;
    bit en_ok = 1'b1;
    poll_en_i = 1'b1;
    while (mode_o == 2'd0 && len < 1000) begin
      if (!sleep_tmr_en_o) en_ok = 1'b0;
      cyc();
      len++;
    end
    check({req, " sleep length"}, len, exp_len);
    check({req, " tmr_en during sleep"}, int'(en_ok), 1);
    check({req, " mode after sleep"}, int'(mode_o), 1);
    check("R2 tmr_en after sleep", int'(sleep_tmr_en_o), 0);
  endtask

  task automatic t_startup();
    off_cmd_i = 1'b1;  // R9 ignored in start-up
    cyc();
    check("R9 off in start-up", int'(mode_o), 1);
    repeat (3) cyc();
    check("R3 start-up holds", int'(mode_o), 1);
    startup_done_i = 1'b1;
    cyc();
    check("R3 start-up exit", int'(mode_o), 2);
  endtask

  task automatic t_fail_high();
    off_cmd_i = 1'b1;
    cyc();
    check("R9 off in bit-check", int'(mode_o), 2);
    poll_en_i  = 1'b1;
    chk_done_i = 1'b1;
    chk_ok_i   = 1'b0;
    cyc();
    check("R5 fail with pin high", int'(mode_o), 0);
  endtask

  task automatic t_fail_low_then_pass();
    poll_en_i  = 1'b0;
    chk_done_i = 1'b1;
    chk_ok_i   = 1'b0;
    cyc();
    check("R5 fail with pin low", int'(mode_o), 2);
    chk_done_i = 1'b1;
    chk_ok_i   = 1'b1;
    cyc();
    check("R4 pass", int'(mode_o), 3);
  endtask

  task automatic t_recv_hold();
    poll_en_i = 1'b0;
    repeat (3) cyc();
    check("R6 hold pin low", int'(mode_o), 3);
    poll_en_i = 1'b1;
    repeat (2) cyc();
    check("R6 hold pin high", int'(mode_o), 3);
  endtask

  task automatic t_off_low();
    poll_en_i = 1'b0;
    off_cmd_i = 1'b1;
    cyc();
    check("R7 off pin low", int'(mode_o), 1);
    check("R7 no sleep", int'(sleep_tmr_en_o), 0);
    startup_done_i = 1'b1;
    cyc();
    check("R7 bit-check active", int'(mode_o), 2);
    chk_done_i = 1'b1;
    chk_ok_i   = 1'b1;
    cyc();
    check("R7 back to receiving", int'(mode_o), 3);
  endtask

  task automatic t_off_high();
    sleep_cycles_i = 8'd3;
    poll_en_i = 1'b1;
    off_cmd_i = 1'b1;
    cyc();
    check("R8 off pin high", int'(mode_o), 0);
    t_sleep_run(3, "R8");
  endtask

  task automatic t_sleep_abort();
    startup_done_i = 1'b1;
    cyc();
    t_fail_high();
    poll_en_i = 1'b0;
    cyc();
    check("R10 pin low ends sleep", int'(mode_o), 1);
  endtask

  task automatic t_noise();
    noise_dis_i = 1'b1;
    check("R11 before edge", int'(noise_dis_o), 0);
    cyc();
    check("R11 rise", int'(noise_dis_o), 1);
    noise_dis_i = 1'b0;
    cyc();
    check("R11 fall", int'(noise_dis_o), 0);
  endtask

  initial begin
    t_reset();
    t_sleep_run(5, "R2 R1");
    t_startup();
    sleep_cycles_i = 8'd0;
    t_fail_high();
    t_sleep_run(1, "R2 zero");
    startup_done_i = 1'b1;
    cyc();
    t_fail_low_then_pass();
    t_recv_hold();
    t_off_low();
    t_off_high();
    t_sleep_abort();
    t_noise();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule